// File: doc/BRIEF.md
# Privilege Access Filter for a Bus Slave Port

This block sits behind one AHB-Lite slave port and splits its traffic between two targets: a bank of control registers and a trace SRAM. Every accepted transfer is classified as coming from user or privileged code, using bit 1 of the protection signal. The block then applies one of two guard bits held in its own control word. One guard covers writes to register space. The other covers all access to the SRAM.

A transfer that the policy blocks still finishes on the bus in the normal way, with ready high and an OKAY response. For register space the guard only suppresses user writes, and user reads still return data. For SRAM a blocked user read returns all zeros, a blocked user write never reaches the memory, and the memory sees no enable at all. The control word itself lives at word 0 of register space. It is reset to 0x80, so after reset register writes are accepted only from privileged code. A user write that is blocked cannot lower the guard, because such a write leaves the whole word unchanged.

The address phase is captured in a register. The decision is applied in the following data phase, with the write data that arrives in that cycle. The SRAM follows a single-cycle model: it takes address and enable in the data phase and returns read data in the same cycle.

Top module: `ahb_priv_filter`

## Requirements
- R1: A transfer is classed as user when hprot[1] is 0 and as privileged when hprot[1] is 1. No other protection bit affects the outcome.
- R2: After reset the control word reads as 0x0000_0080. Bit 7 is the register write guard and bit 8 is the SRAM guard.
- R3: While control bit 7 is 0, user and privileged writes both take effect. A write to word 0 updates the control word. A write to any other register word pulses reg_wr_en with reg_addr set to the word index and reg_wdata set to hwdata.
- R4: While control bit 7 is 1, a user write to register space has no effect. reg_wr_en stays low, and a write to word 0 leaves every bit of the control word unchanged, guard bits included. Privileged writes still take effect.
- R5: Reads of register space are allowed for both classes whatever the guards hold. Word 0 returns the control word, and other words return reg_rdata with reg_rd_en high.
- R6: While control bit 8 is 0, both classes reach the SRAM. sram_en is high, sram_we equals the transfer direction, and a read returns sram_rdata.
- R7: While control bit 8 is 1, a user SRAM access leaves sram_en and sram_we low, and a user read returns hrdata equal to 0. Privileged SRAM access is unaffected.
- R8: hreadyout is always 1 and hresp is always 0 (OKAY), also for blocked transfers.
- R9: A transfer is accepted only when hsel, htrans[1] and hready are all high at a clock edge. Its effect appears in the next cycle. IDLE or BUSY transfers, and transfers with hready low, cause no register, control or SRAM action.
- R10: haddr[ADDR_W-1] picks SRAM space (1) or register space (0). haddr[ADDR_W-2:2] gives the word index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | ADDR_W | Byte address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | Write direction |
| hprot | input | 4 | Protection; bit 1 set means privileged |
| hready | input | 1 | Bus ready, previous transfer finished |
| hwdata | input | DATA_W | Write data (data phase) |
| hreadyout | output | 1 | Slave ready, always 1 |
| hresp | output | 1 | Response, always OKAY (0) |
| hrdata | output | DATA_W | Read data |
| reg_wr_en | output | 1 | Register bank write strobe |
| reg_rd_en | output | 1 | Register bank read strobe |
| reg_addr | output | ADDR_W-3 | Register word index |
| reg_wdata | output | DATA_W | Register write data |
| reg_rdata | input | DATA_W | Register bank read data |
| sram_en | output | 1 | SRAM enable |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | ADDR_W-3 | SRAM word index |
| sram_wdata | output | DATA_W | SRAM write data |
| sram_rdata | input | DATA_W | SRAM read data, same cycle |

## Verification
The main function is swept over all four settings of the two guard bits. Each setting is crossed with the three targets (control word, other register, SRAM), both directions and both privilege classes. This separates a guard that blocks the wrong class from one that blocks the wrong direction or covers the wrong space. Writes to the control word try to flip both guard bits, so a dropped user write can be told apart from a partly applied one. Further transfers use IDLE, BUSY and hready low, which shows that only accepted address phases act.

// File: rtl/ahbpf_pkg.sv
// Package: shared types for the privilege access filter.
// Assumes nothing beyond standard SystemVerilog packages.
package ahbpf_pkg;

    // Target space selected by the top address bit
    typedef enum logic {
        SPACE_REG  = 1'b0,
        SPACE_SRAM = 1'b1
    } space_e;

    // Source of the read data returned in the data phase
    typedef enum logic [1:0] {
        RD_ZERO = 2'd0,
        RD_CTRL = 2'd1,
        RD_REG  = 2'd2,
        RD_SRAM = 2'd3
    } rdsel_e;

    // Bit of hprot that marks a privileged access
    localparam int PROT_PRIV_BIT = 1;

endpackage

// File: rtl/ahbpf_addr_stage.sv
// Address stage: captures an accepted address phase and holds it for the
// following data phase. Assumes the slave never stretches a transfer, so
// every data phase lasts exactly one cycle.
module ahbpf_addr_stage
    import ahbpf_pkg::*;
#(
    parameter int ADDR_W = 12,
    localparam int IDX_W = ADDR_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [3:0]        hprot,
    input  logic              hready,
    output logic              dp_valid,
    output logic              dp_write,
    output logic              dp_user,
    output space_e            dp_space,
    output logic [IDX_W-1:0]  dp_idx
);

    logic accept;

    // An address phase counts only for NONSEQ/SEQ with the bus ready
    assign accept = hsel && htrans[1] && hready;

    // Hold the decoded address phase for one data phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_valid <= 1'b0;
            dp_write <= 1'b0;
            dp_user  <= 1'b0;
            dp_space <= SPACE_REG;
            dp_idx   <= '0;
        end else begin
            dp_valid <= accept;
            if (accept) begin
                dp_write <= hwrite;
                dp_user  <= !hprot[PROT_PRIV_BIT];
                dp_space <= space_e'(haddr[ADDR_W-1]);
                dp_idx   <= haddr[ADDR_W-2:2];
            end
        end
    end

endmodule

// File: rtl/ahbpf_policy.sv
// Policy: pure combinational decision on the held data phase. Turns class,
// direction and space into strobes for the targets and a read-data select.
// Assumes word 0 of register space is the local control word.
module ahbpf_policy
    import ahbpf_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic             dp_valid,
    input  logic             dp_write,
    input  logic             dp_user,
    input  space_e           dp_space,
    input  logic [IDX_W-1:0] dp_idx,
    input  logic             reg_guard,
    input  logic             ram_guard,
    output logic             ctrl_we,
    output logic             reg_wr_en,
    output logic             reg_rd_en,
    output logic             sram_en,
    output logic             sram_we,
    output rdsel_e           rd_sel
);

    logic is_ctrl;
    logic reg_wr_ok;
    logic ram_ok;

    // Decode guards against the access class
    always_comb begin
        is_ctrl   = (dp_space == SPACE_REG) && (dp_idx == '0);
        reg_wr_ok = !(dp_user && reg_guard);
        ram_ok    = !(dp_user && ram_guard);
    end

    // Generate target strobes and the read-data select
    always_comb begin
        ctrl_we   = 1'b0;
        reg_wr_en = 1'b0;
        reg_rd_en = 1'b0;
        sram_en   = 1'b0;
        sram_we   = 1'b0;
        rd_sel    = RD_ZERO;
        if (dp_valid) begin
            if (dp_space == SPACE_SRAM) begin
                sram_en = ram_ok;
                sram_we = ram_ok && dp_write;
                if (!dp_write && ram_ok) rd_sel = RD_SRAM;
            end else if (is_ctrl) begin
                ctrl_we = dp_write && reg_wr_ok;
                if (!dp_write) rd_sel = RD_CTRL;
            end else begin
                reg_wr_en = dp_write && reg_wr_ok;
                reg_rd_en = !dp_write;
                if (!dp_write) rd_sel = RD_REG;
            end
        end
    end

endmodule

// File: rtl/ahbpf_ctrl_reg.sv
// Control word: holds the guard bits and the rest of word 0. Loads the whole
// word on a permitted write. Assumes write data is valid when load is high.
module ahbpf_ctrl_reg #(
    parameter int              DATA_W    = 32,
    parameter logic [DATA_W-1:0] RESET_VAL = 'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value
);

    // Reset to the guarded value, reload on permitted writes
    always_ff @(posedge clk) begin
        if (!rst_n)    value <= RESET_VAL;
        else if (load) value <= wdata;
    end

endmodule

// File: rtl/ahb_priv_filter.sv
// Top: privilege filter between one AHB-Lite slave port, a register bank
// and a trace SRAM. Never stalls and never returns an error; blocked
// transfers are silently dropped or read as zero. Assumes a single-cycle
// SRAM whose read data is valid in the data phase.
module ahb_priv_filter
    import ahbpf_pkg::*;
#(
    parameter int                DATA_W       = 32,
    parameter int                ADDR_W       = 12,
    parameter int                REG_GUARD_BIT = 7,
    parameter int                RAM_GUARD_BIT = 8,
    parameter logic [DATA_W-1:0] CTRL_RESET   = 'h80,
    localparam int               IDX_W        = ADDR_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [3:0]        hprot,
    input  logic              hready,
    input  logic [DATA_W-1:0] hwdata,
    output logic              hreadyout,
    output logic              hresp,
    output logic [DATA_W-1:0] hrdata,
    output logic              reg_wr_en,
    output logic              reg_rd_en,
    output logic [IDX_W-1:0]  reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              sram_en,
    output logic              sram_we,
    output logic [IDX_W-1:0]  sram_addr,
    output logic [DATA_W-1:0] sram_wdata,
    input  logic [DATA_W-1:0] sram_rdata
);

    logic              dp_valid;
    logic              dp_write;
    logic              dp_user;
    space_e            dp_space;
    logic [IDX_W-1:0]  dp_idx;
    logic              ctrl_we;
    rdsel_e            rd_sel;
    logic [DATA_W-1:0] ctrl;

    ahbpf_addr_stage #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .hsel     (hsel),
        .haddr    (haddr),
        .htrans   (htrans),
        .hwrite   (hwrite),
        .hprot    (hprot),
        .hready   (hready),
        .dp_valid (dp_valid),
        .dp_write (dp_write),
        .dp_user  (dp_user),
        .dp_space (dp_space),
        .dp_idx   (dp_idx)
    );

    ahbpf_policy #(.IDX_W(IDX_W)) u_policy (
        .dp_valid  (dp_valid),
        .dp_write  (dp_write),
        .dp_user   (dp_user),
        .dp_space  (dp_space),
        .dp_idx    (dp_idx),
        .reg_guard (ctrl[REG_GUARD_BIT]),
        .ram_guard (ctrl[RAM_GUARD_BIT]),
        .ctrl_we   (ctrl_we),
        .reg_wr_en (reg_wr_en),
        .reg_rd_en (reg_rd_en),
        .sram_en   (sram_en),
        .sram_we   (sram_we),
        .rd_sel    (rd_sel)
    );

    ahbpf_ctrl_reg #(.DATA_W(DATA_W), .RESET_VAL(CTRL_RESET)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ctrl_we),
        .wdata (hwdata),
        .value (ctrl)
    );

    // Bus response: zero wait states, always OKAY
    assign hreadyout = 1'b1;
    assign hresp     = 1'b0;

    // Target address and data follow the held data phase
    assign reg_addr   = dp_idx;
    assign reg_wdata  = hwdata;
    assign sram_addr  = dp_idx;
    assign sram_wdata = hwdata;

    // Read-data return mux; blocked reads fall to zero
    always_comb begin
        unique case (rd_sel)
            RD_CTRL: hrdata = ctrl;
            RD_REG:  hrdata = reg_rdata;
            RD_SRAM: hrdata = sram_rdata;
            default: hrdata = '0;
        endcase
    end

endmodule

// File: rtl/ahbpf_checker.sv
// Checker: temporal properties of the privilege filter, bound to the top.
// Assumes the default guard bit positions 7 and 8.
module ahbpf_checker
    import ahbpf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12,
    localparam int IDX_W = ADDR_W - 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hsel,
    input logic [1:0]        htrans,
    input logic              hwrite,
    input logic [3:0]        hprot,
    input logic              hready,
    input logic              hreadyout,
    input logic              hresp,
    input logic [DATA_W-1:0] hrdata,
    input logic              reg_wr_en,
    input logic              sram_en,
    input logic              sram_we,
    input logic              dp_valid,
    input logic              dp_write,
    input logic              dp_user,
    input space_e            dp_space,
    input logic [IDX_W-1:0]  dp_idx,
    input logic [DATA_W-1:0] ctrl
);

    // R8: never stall, never error
    p_okay_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hreadyout && !hresp);

    // R2: first cycle out of reset holds the reset control word
    p_reset_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ctrl == DATA_W'('h80));

    // R4: a guarded user write to word 0 leaves the control word intact
    p_ctrl_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_valid && dp_write && dp_user && dp_space == SPACE_REG
         && dp_idx == '0 && ctrl[7]) |=> $stable(ctrl));

    // R4: a guarded user register write accepted last cycle gives no strobe
    p_no_user_reg_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hsel && htrans[1] && hready && hwrite
         && !hprot[PROT_PRIV_BIT]) && dp_space == SPACE_REG && ctrl[7])
        |-> !reg_wr_en);

    // R7: guarded user SRAM access gives no enable and reads zero
    p_user_sram_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_valid && dp_user && dp_space == SPACE_SRAM && ctrl[8])
        |-> (!sram_en && !sram_we && hrdata == '0));

    // R9: no target strobe without an accepted address phase before
    p_no_action_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(hsel && htrans[1] && hready))
        |-> (!reg_wr_en && !sram_en));

endmodule

bind ahb_priv_filter ahbpf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hsel      (hsel),
    .htrans    (htrans),
    .hwrite    (hwrite),
    .hprot     (hprot),
    .hready    (hready),
    .hreadyout (hreadyout),
    .hresp     (hresp),
    .hrdata    (hrdata),
    .reg_wr_en (reg_wr_en),
    .sram_en   (sram_en),
    .sram_we   (sram_we),
    .dp_valid  (dp_valid),
    .dp_write  (dp_write),
    .dp_user   (dp_user),
    .dp_space  (dp_space),
    .dp_idx    (dp_idx),
    .ctrl      (ctrl)
);

// File: tb/test_ahb_priv_filter.sv
// Bench: sweeps guard settings x target x direction x class, plus
// non-accepted transfer types, with expected values computed here.
module test_ahb_priv_filter;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;
    localparam int IDX_W  = ADDR_W - 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hsel = 1'b0;
    logic [ADDR_W-1:0] haddr = '0;
    logic [1:0]        htrans = 2'b00;
    logic              hwrite = 1'b0;
    logic [3:0]        hprot = 4'h0;
    logic              hready = 1'b1;
    logic [DATA_W-1:0] hwdata = '0;
    logic              hreadyout, hresp;
    logic [DATA_W-1:0] hrdata;
    logic              reg_wr_en, reg_rd_en, sram_en, sram_we;
    logic [IDX_W-1:0]  reg_addr, sram_addr;
    logic [DATA_W-1:0] reg_wdata, sram_wdata, reg_rdata, sram_rdata;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    // Target models: read data is a pattern of the word index
    assign reg_rdata  = 32'hC0DE_0000 | DATA_W'(reg_addr);
    assign sram_rdata = 32'h5A70_0000 | DATA_W'(sram_addr);

    ahb_priv_filter i_ahb_priv_filter (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr),
        .htrans(htrans), .hwrite(hwrite), .hprot(hprot), .hready(hready),
        .hwdata(hwdata), .hreadyout(hreadyout), .hresp(hresp),
        .hrdata(hrdata), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sram_en(sram_en), .sram_we(sram_we), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
    );

    task automatic chk(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One transfer; outputs sampled mid data phase into the out arguments
    task automatic xfer(input logic sram, input logic [IDX_W-1:0] idx,
                        input logic wr, input logic priv,
                        input logic [1:0] tr, input logic rdy,
                        input logic [DATA_W-1:0] wd,
                        output logic [DATA_W-1:0] rd,
                        output logic [3:0] strobes);
        @(negedge clk);
        hsel   = 1'b1;
        haddr  = {sram, idx, 2'b00};
        hwrite = wr;
        hprot  = {2'b10, priv, 1'b1};
        htrans = tr;
        hready = rdy;
        @(negedge clk);
        hsel   = 1'b0;
        htrans = 2'b00;
        hready = 1'b1;
        hwdata = wd;
        #1;
        rd      = hrdata;
        strobes = {reg_wr_en, reg_rd_en, sram_en, sram_we};
        chk("R8 ready/okay", {30'd0, hreadyout, hresp}, 32'd2);
    endtask

    task automatic set_ctrl(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] rd;
        logic [3:0] st;
        xfer(1'b0, '0, 1'b1, 1'b1, 2'b10, 1'b1, v, rd, st);
    endtask

    task automatic read_ctrl(output logic [DATA_W-1:0] v);
        logic [3:0] st;
        xfer(1'b0, '0, 1'b0, 1'b1, 2'b10, 1'b1, '0, v, st);
    endtask

    initial begin
        #(100000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] rd, cv, wd, exp_ctrl;
        logic [3:0] st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 idle outputs", {30'd0, hreadyout, hresp}, 32'd2);
        read_ctrl(rd);
        chk("R2 reset control word", rd, 32'h0000_0080);

        // Sweep guards x target x direction x class
        for (int cfg = 0; cfg < 4; cfg++) begin
            for (int sp = 0; sp < 3; sp++) begin
                for (int w = 0; w < 2; w++) begin
                    for (int p = 0; p < 2; p++) begin
                        logic g_reg, g_ram, user, wrb, ok;
                        logic [IDX_W-1:0] idx;
                        g_reg = cfg[0];
                        g_ram = cfg[1];
                        user  = (p == 0);
                        wrb   = (w == 1);
                        cv    = 32'h1000_0000 | (32'(g_reg) << 7) | (32'(g_ram) << 8);
                        set_ctrl(cv);
                        idx   = (sp == 1) ? IDX_W'(5 + cfg) : '0;
                        wd    = (sp == 0) ? (cv ^ 32'h0000_0185)
                                          : (32'hD000_0000 | 32'(cfg * 16 + sp * 4 + w * 2 + p));
                        xfer(sp == 2, idx, wrb, !user, 2'b10, 1'b1, wd, rd, st);
                        if (sp == 0) begin
                            // R1 R3 R4 R5: control word target
                            ok = !(user && g_reg);
                            chk("R5 no bank strobe on word 0", 32'(st), 32'd0);
                            if (wrb) begin
                                read_ctrl(rd);
                                exp_ctrl = ok ? wd : cv;
                                chk(ok ? "R3 control write applied" : "R4 user control write dropped",
                                    rd, exp_ctrl);
                            end else begin
                                chk("R5 control read by either class", rd, cv);
                            end
                        end else if (sp == 1) begin
                            ok = !(user && g_reg);
                            if (wrb) begin
                                chk(ok ? "R3 register write strobe" : "R4 user register write blocked",
                                    32'(st), ok ? 32'b1000 : 32'b0000);
                                if (ok) chk("R3 register addr/data",
                                            {reg_wdata[31:IDX_W], reg_addr},
                                            {wd[31:IDX_W], idx});
                            end else begin
                                chk("R5 register read strobe", 32'(st), 32'b0100);
                                chk("R5 register read data R10", rd, 32'hC0DE_0000 | 32'(idx));
                            end
                        end else begin
                            ok = !(user && g_ram);
                            chk(ok ? "R6 SRAM strobes" : "R7 user SRAM strobes blocked",
                                32'(st), ok ? (wrb ? 32'b0011 : 32'b0010) : 32'b0000);
                            if (!wrb)
                                chk(ok ? "R6 SRAM read data R10" : "R7 user SRAM reads zero",
                                    rd, ok ? 32'h5A70_0000 : 32'h0);
                            else if (ok)
                                chk("R6 SRAM write data", sram_wdata, wd);
                        end
                    end
                end
            end
        end

        // R1: only hprot[1] decides the class (other bits set for user)
        set_ctrl(32'h0000_0080);
        @(negedge clk);
        hsel = 1'b1; haddr = {1'b0, IDX_W'(3), 2'b00}; hwrite = 1'b1;
        hprot = 4'b1101; htrans = 2'b10;
        @(negedge clk);
        hsel = 1'b0; htrans = 2'b00; hwdata = 32'h1234_5678;
        #1;
        chk("R1 user despite other hprot bits", 32'(reg_wr_en), 32'd0);

        // R9: IDLE, BUSY and hready-low transfers do nothing
        set_ctrl(32'h0000_0000);
        xfer(1'b0, '0, 1'b1, 1'b0, 2'b00, 1'b1, 32'hFFFF_FFFF, rd, st);
        chk("R9 IDLE no strobes", 32'(st), 32'd0);
        xfer(1'b0, '0, 1'b1, 1'b1, 2'b01, 1'b1, 32'hFFFF_FFFF, rd, st);
        chk("R9 BUSY no strobes", 32'(st), 32'd0);
        xfer(1'b1, IDX_W'(2), 1'b1, 1'b1, 2'b10, 1'b0, 32'hFFFF_FFFF, rd, st);
        chk("R9 hready low no SRAM write", 32'(st), 32'd0);
        xfer(1'b0, IDX_W'(2), 1'b1, 1'b1, 2'b11, 1'b1, 32'h0000_0001, rd, st);
        chk("R9 SEQ accepted", 32'(st), 32'b1000);
        read_ctrl(rd);
        chk("R9 control untouched by ignored transfers", rd, 32'h0000_0000);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule